// File: doc/BRIEF.md
# TDM Frame Sync and Slot Serializer

This block drives the transmit side of a time-division-multiplexed audio link as bus master. It produces a bit clock, a frame sync and one serial data line. Every aspect of the framing comes from static configuration inputs: the frame length, the sync width, whether the sync marks only the start of a frame or identifies the channel, its polarity, and whether it leads the first data bit by one bit clock. The slot count, the slot width, the sample size, the first-bit offset inside a slot, a slot enable mask and the bit clock edge used for data changes are also inputs. Setting the sync width to half the frame with the early option gives I2S. Setting it to one bit, with or without the early option, gives the two DSP styles. Left- or right-justified layouts come from the first-bit offset.

Samples arrive right-aligned on a valid/ready port. The block pulls one word at the first bit of each enabled slot and shifts it out MSB first. Disabled slots, slot padding and bits past the last slot are driven low. When no word is waiting, the block sends zeros and raises an underrun pulse. Each bit lasts two clock cycles. The system clock must therefore be twice the bit rate.

Top module: `tdm_frame_serializer`

## Requirements
- R1: The frame lasts `cfg_frame_len_m1`+1 bit periods and repeats without gaps. One bit period is two clock cycles. The bit counter restarts at the end of each frame.
- R2: In start-of-frame mode (`cfg_fs_chan`=0), frame sync is active for `cfg_fs_len_m1`+1 bit periods.
- R3: In channel-identification mode (`cfg_fs_chan`=1), frame sync is active for half the frame and `cfg_fs_len_m1` is ignored.
- R4: With `cfg_fs_early`=1, frame sync goes active one bit period before bit 0 of slot 0 (the last bit of the previous frame). With `cfg_fs_early`=0 it goes active on bit 0.
- R5: `cfg_fs_pol`=1 makes active sync high and `cfg_fs_pol`=0 makes it low. After reset and while the configuration is illegal, `fs_o` sits at the inactive level.
- R6: Sample size code 2/3/4/5/6/7 means 8/10/16/20/24/32 bits. Slot size code 1 means 16 bits, code 2 means 32 bits, and codes 0 and 3 mean a slot as wide as the sample.
- R7: In an enabled slot, the sample goes out MSB first starting at slot bit `cfg_first_bit`. Slot bits before and after that field are 0.
- R8: A slot whose mask bit is 0 sends all zeros and takes no word. Bit periods after the last slot (slot index ≥ `cfg_slots_m1`+1) also send zeros.
- R9: A zero `cfg_slot_mask` enables slots 0 to `cfg_slots_m1`.
- R10: With `cfg_mono`=1 and two slots, slot 1 resends the slot 0 sample without taking a new word.
- R11: If `s_valid` is low when a slot starts that needs a word, the slot sends zeros and `underrun_o` is high for exactly one clock cycle.
- R12: A sample size code below 2, or a slot width smaller than the sample size, is illegal. While it is illegal: `sd_o` is 0, `fs_o` is inactive, `s_ready` stays low and no underrun is reported.
- R13: `sck_o` equals `cfg_sck_rise` in the cycle after each data update and is inverted in the other cycle. So with 1, data changes on the rising bit clock edge, and with 0, on the falling edge.
- R14: `s_ready` is high only in the update cycle of the first bit of a slot that takes a word. A word is transferred when `s_valid` and `s_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frame_len_m1 | input | 8 | Frame length in bit periods, minus one |
| cfg_fs_len_m1 | input | 8 | Sync active length minus one (start-of-frame mode) |
| cfg_fs_early | input | 1 | Sync leads slot 0 by one bit period |
| cfg_fs_pol | input | 1 | Active level of frame sync |
| cfg_fs_chan | input | 1 | 1: sync is a half-frame channel indicator |
| cfg_slots_m1 | input | 4 | Slot count minus one |
| cfg_slot_size | input | 2 | Slot width code |
| cfg_data_size | input | 3 | Sample size code |
| cfg_first_bit | input | 5 | Bit position in the slot where the sample MSB goes |
| cfg_slot_mask | input | 16 | Per-slot enable, zero selects the default |
| cfg_mono | input | 1 | Repeat slot 0 sample in slot 1 when two slots |
| cfg_sck_rise | input | 1 | Data changes on rising (1) or falling (0) bit clock edge |
| s_data | input | 32 | Right-aligned sample word |
| s_valid | input | 1 | Sample word available |
| s_ready | output | 1 | Sample word taken this cycle |
| sck_o | output | 1 | Bit clock |
| sd_o | output | 1 | Serial data |
| fs_o | output | 1 | Frame sync |
| underrun_o | output | 1 | One-cycle pulse when a slot found no sample |

## Verification
The main path runs with several framing patterns. An I2S-like frame has two slots, an automatic slot width and a channel-style sync with a decoy length field; it separates half-frame sync from field-driven sync and checks the early offset. A four-slot, 32-bit slot frame carries 24-bit samples shifted by 8 with one slot masked off; it exposes offset, MSB-order and skipping errors. A three-slot, 10-bit frame is shorter than the frame length and uses the default mask; it catches trailing-bit and default-mask faults together with a multi-bit, early sync. A mono frame and a starved frame of 32-bit samples show sample reuse and underrun zero-filling, and two illegal size pairs show the idle behaviour. Every bit period is compared against a bench model of data, sync, bit clock level, ready and underrun.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  // Sample width in bits for a sample size code; 0 marks an unusable code.
  function automatic logic [5:0] sample_bits(input logic [2:0] code);
    case (code)
      3'd2:    sample_bits = 6'd8;
      3'd3:    sample_bits = 6'd10;
      3'd4:    sample_bits = 6'd16;
      3'd5:    sample_bits = 6'd20;
      3'd6:    sample_bits = 6'd24;
      3'd7:    sample_bits = 6'd32;
      default: sample_bits = 6'd0;
    endcase
  endfunction

  // Slot width in bits; automatic codes follow the sample width.
  function automatic logic [5:0] slot_bits(input logic [1:0] code, input logic [5:0] smp);
    case (code)
      2'd1:    slot_bits = 6'd16;
      2'd2:    slot_bits = 6'd32;
      default: slot_bits = smp;
    endcase
  endfunction

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
  parameter int FRL_W = 8,
  parameter int IDX_W = 5,
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [FRL_W-1:0] frame_len_m1,
  input  logic [POS_W:0]   slot_len,
  output logic             tick,
  output logic [FRL_W-1:0] bit_idx,
  output logic [IDX_W-1:0] slot_idx,
  output logic [POS_W-1:0] slot_pos
);

  logic phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  assign tick = ~phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bit_idx  <= '0;
      slot_idx <= '0;
      slot_pos <= '0;
    end else if (tick) begin
      if (bit_idx >= frame_len_m1) begin
        bit_idx  <= '0;
        slot_idx <= '0;
        slot_pos <= '0;
      end else begin
        bit_idx <= bit_idx + 1'b1;
        if ({1'b0, slot_pos} >= slot_len - 1'b1) begin
          slot_pos <= '0;
          if (slot_idx != '1) slot_idx <= slot_idx + 1'b1;
        end else begin
          slot_pos <= slot_pos + 1'b1;
        end
      end
    end
  end

  // R13
  tick_alt_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick && bit_idx == frame_len_m1 && $stable(frame_len_m1)) |=> (bit_idx == '0));

endmodule

// File: rtl/tdm_frame_sync.sv
module tdm_frame_sync #(
  parameter int FRL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic [FRL_W-1:0] bit_idx,
  input  logic [FRL_W-1:0] frame_len_m1,
  input  logic [FRL_W-1:0] fs_len_m1,
  input  logic             early,
  input  logic             pol,
  input  logic             chan,
  output logic             fs_o
);

  logic [FRL_W:0] frame_bits;
  logic [FRL_W:0] lead_pos;
  logic [FRL_W:0] act_len;
  logic           active;

  always_comb begin
    frame_bits = {1'b0, frame_len_m1} + 1'b1;
    lead_pos   = {1'b0, bit_idx} + {{FRL_W{1'b0}}, early};
    if (lead_pos > {1'b0, frame_len_m1}) lead_pos = '0;
    act_len = chan ? (frame_bits >> 1) : ({1'b0, fs_len_m1} + 1'b1);
    active  = lead_pos < act_len;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) fs_o <= ~pol;
    else if (tick)   fs_o <= active ? pol : ~pol;
  end

  // R5
  fs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (fs_o == !$past(pol)));

endmodule

// File: rtl/tdm_slot_shifter.sv
module tdm_slot_shifter #(
  parameter int WORD_W = 32,
  parameter int SLOTS  = 16,
  parameter int SEL_W  = 4,
  parameter int IDX_W  = 5,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic [IDX_W-1:0]  slot_idx,
  input  logic [POS_W-1:0]  slot_pos,
  input  logic [SEL_W-1:0]  slots_m1,
  input  logic [SLOTS-1:0]  mask,
  input  logic              mono,
  input  logic [POS_W-1:0]  first_bit,
  input  logic [5:0]        smp_bits,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              sd_o,
  output logic              underrun_o
);

  logic [IDX_W-1:0]  slot_cnt;
  logic [SLOTS-1:0]  def_mask;
  logic [SLOTS-1:0]  use_mask;
  logic              in_frame;
  logic              slot_on;
  logic              reuse_slot;
  logic              fetch;
  logic [WORD_W-1:0] hold_word;
  logic [WORD_W-1:0] word_now;
  logic [POS_W-1:0]  bsel;
  logic              in_field;
  logic              bit_val;
  int                rel;

  assign slot_cnt = {1'b0, slots_m1} + 1'b1;

  for (genvar i = 0; i < SLOTS; i++) begin : g_def
    assign def_mask[i] = (IDX_W'(i) < slot_cnt);
  end

  assign use_mask   = (mask == '0) ? def_mask : mask;
  assign in_frame   = slot_idx < slot_cnt;
  assign slot_on    = in_frame && use_mask[slot_idx[SEL_W-1:0]];
  assign reuse_slot = mono && (slots_m1 == SEL_W'(1)) && (slot_idx == IDX_W'(1));
  assign fetch      = !rst && run && tick && (slot_pos == '0) && slot_on && !reuse_slot;
  assign s_ready    = fetch;
  assign word_now   = fetch ? (s_valid ? s_data : '0) : hold_word;

  always_comb begin
    rel      = int'(slot_pos) - int'(first_bit);
    in_field = (rel >= 0) && (rel < int'(smp_bits));
    bsel     = in_field ? POS_W'(int'(smp_bits) - 1 - rel) : '0;
    bit_val  = slot_on && in_field && word_now[bsel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word  <= '0;
      sd_o       <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      underrun_o <= fetch && !s_valid;
      if (fetch) hold_word <= word_now;
      if (!run)      sd_o <= 1'b0;
      else if (tick) sd_o <= bit_val;
    end
  end

  // R14
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (rst) s_ready |-> (tick && run));

  // R11
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (rst) underrun_o |=> !underrun_o);

  // R12
  idle_data_chk: assert property (@(posedge clk) disable iff (rst) !run |=> !sd_o);

  // R8
  beyond_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !in_frame) |=> (!sd_o && !underrun_o));

endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer
  import tdm_ser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SLOTS  = 16,
  parameter int FRL_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [FRL_W-1:0]           cfg_frame_len_m1,
  input  logic [FRL_W-1:0]           cfg_fs_len_m1,
  input  logic                       cfg_fs_early,
  input  logic                       cfg_fs_pol,
  input  logic                       cfg_fs_chan,
  input  logic [$clog2(SLOTS)-1:0]   cfg_slots_m1,
  input  logic [1:0]                 cfg_slot_size,
  input  logic [2:0]                 cfg_data_size,
  input  logic [$clog2(WORD_W)-1:0]  cfg_first_bit,
  input  logic [SLOTS-1:0]           cfg_slot_mask,
  input  logic                       cfg_mono,
  input  logic                       cfg_sck_rise,
  input  logic [WORD_W-1:0]          s_data,
  input  logic                       s_valid,
  output logic                       s_ready,
  output logic                       sck_o,
  output logic                       sd_o,
  output logic                       fs_o,
  output logic                       underrun_o
);

  localparam int SEL_W = $clog2(SLOTS);
  localparam int IDX_W = SEL_W + 1;
  localparam int POS_W = $clog2(WORD_W);

  logic [5:0]       smp_len;
  logic [5:0]       slt_len;
  logic             legal;
  logic             tick;
  logic [FRL_W-1:0] bit_idx;
  logic [IDX_W-1:0] slot_idx;
  logic [POS_W-1:0] slot_pos;

  assign smp_len = sample_bits(cfg_data_size);
  assign slt_len = slot_bits(cfg_slot_size, smp_len);
  assign legal   = (smp_len != 6'd0) && (slt_len >= smp_len);

  tdm_bit_timer #(.FRL_W(FRL_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .run          (legal),
    .frame_len_m1 (cfg_frame_len_m1),
    .slot_len     ((POS_W+1)'(slt_len)),
    .tick         (tick),
    .bit_idx      (bit_idx),
    .slot_idx     (slot_idx),
    .slot_pos     (slot_pos)
  );

  tdm_frame_sync #(.FRL_W(FRL_W)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .run          (legal),
    .bit_idx      (bit_idx),
    .frame_len_m1 (cfg_frame_len_m1),
    .fs_len_m1    (cfg_fs_len_m1),
    .early        (cfg_fs_early),
    .pol          (cfg_fs_pol),
    .chan         (cfg_fs_chan),
    .fs_o         (fs_o)
  );

  tdm_slot_shifter #(
    .WORD_W (WORD_W),
    .SLOTS  (SLOTS),
    .SEL_W  (SEL_W),
    .IDX_W  (IDX_W),
    .POS_W  (POS_W)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .run        (legal),
    .slot_idx   (slot_idx),
    .slot_pos   (slot_pos),
    .slots_m1   (cfg_slots_m1),
    .mask       (cfg_slot_mask),
    .mono       (cfg_mono),
    .first_bit  (cfg_first_bit),
    .smp_bits   (smp_len),
    .s_data     (s_data),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .sd_o       (sd_o),
    .underrun_o (underrun_o)
  );

  always_ff @(posedge clk) begin
    if (rst) sck_o <= 1'b0;
    else     sck_o <= tick ? cfg_sck_rise : ~cfg_sck_rise;
  end

  // R13
  sck_edge_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (sck_o == $past(cfg_sck_rise)));

  // R12
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !legal |-> !s_ready);

endmodule

// File: tb/test_tdm_frame_serializer.sv
module test_tdm_frame_serializer;

  localparam int PERIOD = 10;
  localparam int LIMIT  = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_frame_len_m1 = 8'd31;
  logic [7:0]  cfg_fs_len_m1 = 8'd0;
  logic        cfg_fs_early = 1'b0;
  logic        cfg_fs_pol = 1'b1;
  logic        cfg_fs_chan = 1'b0;
  logic [3:0]  cfg_slots_m1 = 4'd1;
  logic [1:0]  cfg_slot_size = 2'd0;
  logic [2:0]  cfg_data_size = 3'd4;
  logic [4:0]  cfg_first_bit = 5'd0;
  logic [15:0] cfg_slot_mask = 16'd0;
  logic        cfg_mono = 1'b0;
  logic        cfg_sck_rise = 1'b0;
  logic [31:0] s_data = 32'd0;
  logic        s_valid = 1'b0;
  logic        s_ready, sck_o, sd_o, fs_o, underrun_o;

  int total = 0;
  int bad = 0;
  logic [31:0] wq [0:63];
  int head = 0;
  int tail = 0;

  always #(PERIOD/2) clk = ~clk;

  tdm_frame_serializer i_tdm_frame_serializer (
    .clk(clk), .rst(rst),
    .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_fs_len_m1(cfg_fs_len_m1),
    .cfg_fs_early(cfg_fs_early), .cfg_fs_pol(cfg_fs_pol), .cfg_fs_chan(cfg_fs_chan),
    .cfg_slots_m1(cfg_slots_m1), .cfg_slot_size(cfg_slot_size), .cfg_data_size(cfg_data_size),
    .cfg_first_bit(cfg_first_bit), .cfg_slot_mask(cfg_slot_mask), .cfg_mono(cfg_mono),
    .cfg_sck_rise(cfg_sck_rise), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .sck_o(sck_o), .sd_o(sd_o), .fs_o(fs_o), .underrun_o(underrun_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic load_words(input int n, input logic [31:0] seed);
    head = 0;
    tail = n;
    for (int i = 0; i < n; i++) wq[i] = seed ^ (32'h9E3779B9 * (i + 1));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    s_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int smp_w(input logic [2:0] c);
    case (c)
      3'd2: return 8;
      3'd3: return 10;
      3'd4: return 16;
      3'd5: return 20;
      3'd6: return 24;
      3'd7: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic int slot_w(input logic [1:0] c, input int s);
    if (c == 2'd1) return 16;
    if (c == 2'd2) return 32;
    return s;
  endfunction

  // Runs whole frames from a fresh reset and compares every bit period with the model.
  task automatic run_frames(input int nfr, input string sd_tag, input string fs_tag);
    int fbits, ds, sw, n, flen, slot, pos, rel;
    logic [15:0] em;
    logic [31:0] curw;
    bit on, reuse, want, empty, exp_sd, exp_fs, rdy;
    fbits = cfg_frame_len_m1 + 1;
    ds = smp_w(cfg_data_size);
    sw = slot_w(cfg_slot_size, ds);
    n = cfg_slots_m1 + 1;
    em = (cfg_slot_mask == 16'd0) ? 16'((32'd1 << n) - 1) : cfg_slot_mask;
    flen = cfg_fs_chan ? fbits / 2 : cfg_fs_len_m1 + 1;
    curw = 32'd0;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int b = 0; b < fbits; b++) begin
        slot = b / sw;
        pos = b % sw;
        on = (slot < n) && em[slot];
        reuse = cfg_mono && (n == 2) && (slot == 1);
        want = on && (pos == 0) && !reuse;
        empty = (head >= tail);
        s_valid = !empty;
        s_data = empty ? 32'hDEAD_BEEF : wq[head];
        #1;
        rdy = s_ready;
        chk(rdy == want, "R14 ready", 32'(rdy), 32'(want));
        if (want) curw = empty ? 32'd0 : wq[head];
        @(posedge clk);
        if (rdy && s_valid) head++;
        @(negedge clk);
        rel = pos - cfg_first_bit;
        exp_sd = on && (rel >= 0) && (rel < ds) && curw[ds - 1 - rel];
        exp_fs = (((b + cfg_fs_early) % fbits) < flen) ? cfg_fs_pol : !cfg_fs_pol;
        chk(sd_o == exp_sd, sd_tag, 32'(sd_o), 32'(exp_sd));
        chk(fs_o == exp_fs, fs_tag, 32'(fs_o), 32'(exp_fs));
        chk(underrun_o == (want && empty), "R11 underrun", 32'(underrun_o), 32'(want && empty));
        chk(sck_o == cfg_sck_rise, "R13 sck after update", 32'(sck_o), 32'(cfg_sck_rise));
        @(negedge clk);
        chk(sck_o == !cfg_sck_rise, "R13 sck mid bit", 32'(sck_o), 32'(!cfg_sck_rise));
      end
    end
    s_valid = 1'b0;
  endtask

  task automatic t_reset();
    cfg_fs_pol = 1'b0;
    rst = 1'b1;
    s_valid = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(sd_o == 1'b0, "R5 reset sd", 32'(sd_o), 0);
    chk(fs_o == 1'b1, "R5 reset fs inactive", 32'(fs_o), 1);
    chk(underrun_o == 1'b0, "R11 reset underrun", 32'(underrun_o), 0);
    chk(s_ready == 1'b0, "R14 reset ready", 32'(s_ready), 0);
    s_valid = 1'b0;
  endtask

  // R1 R3 R4 R5 R6 R9: two 16-bit slots, channel sync, early, active low
  task automatic t_i2s_like();
    cfg_frame_len_m1 = 8'd31; cfg_fs_len_m1 = 8'd2; cfg_fs_chan = 1'b1;
    cfg_fs_early = 1'b1; cfg_fs_pol = 1'b0; cfg_slots_m1 = 4'd1;
    cfg_slot_size = 2'd0; cfg_data_size = 3'd4; cfg_first_bit = 5'd0;
    cfg_slot_mask = 16'd0; cfg_mono = 1'b0; cfg_sck_rise = 1'b0;
    load_words(6, 32'h1234_5678);
    do_reset();
    run_frames(3, "R7 R9 i2s data", "R3 R4 R5 i2s sync");
    chk(head == 6, "R1 R9 words used", 32'(head), 6);
  endtask

  // R2 R7 R8 R13: 24-bit samples at offset 8 in 32-bit slots, slot 2 masked
  task automatic t_right_just();
    cfg_frame_len_m1 = 8'd127; cfg_fs_len_m1 = 8'd0; cfg_fs_chan = 1'b0;
    cfg_fs_early = 1'b0; cfg_fs_pol = 1'b1; cfg_slots_m1 = 4'd3;
    cfg_slot_size = 2'd2; cfg_data_size = 3'd6; cfg_first_bit = 5'd8;
    cfg_slot_mask = 16'b1011; cfg_mono = 1'b0; cfg_sck_rise = 1'b1;
    load_words(6, 32'hCAFE_0F0F);
    do_reset();
    run_frames(2, "R7 R8 right justified", "R2 one-bit sync");
    chk(head == 6, "R8 masked slot takes no word", 32'(head), 6);
  endtask

  // R1 R2 R4 R8 R9: three 16-bit slots of 10-bit samples in a 64-bit frame
  task automatic t_short_slots();
    cfg_frame_len_m1 = 8'd63; cfg_fs_len_m1 = 8'd3; cfg_fs_chan = 1'b0;
    cfg_fs_early = 1'b1; cfg_fs_pol = 1'b1; cfg_slots_m1 = 4'd2;
    cfg_slot_size = 2'd1; cfg_data_size = 3'd3; cfg_first_bit = 5'd0;
    cfg_slot_mask = 16'd0; cfg_mono = 1'b0; cfg_sck_rise = 1'b0;
    load_words(6, 32'h0BAD_F00D);
    do_reset();
    run_frames(2, "R6 R8 trailing zeros", "R1 R2 R4 multi-bit early sync");
  endtask

  // R10: mono, 20-bit samples at offset 12 in 32-bit slots
  task automatic t_mono();
    cfg_frame_len_m1 = 8'd63; cfg_fs_len_m1 = 8'd0; cfg_fs_chan = 1'b1;
    cfg_fs_early = 1'b0; cfg_fs_pol = 1'b1; cfg_slots_m1 = 4'd1;
    cfg_slot_size = 2'd2; cfg_data_size = 3'd5; cfg_first_bit = 5'd12;
    cfg_slot_mask = 16'd0; cfg_mono = 1'b1; cfg_sck_rise = 1'b1;
    load_words(2, 32'h5A5A_3C3C);
    do_reset();
    run_frames(2, "R10 mono repeat", "R3 channel sync");
    chk(head == 2, "R10 one word per frame", 32'(head), 2);
  endtask

  // R11: 32-bit samples, only three of four words available
  task automatic t_underrun();
    cfg_frame_len_m1 = 8'd63; cfg_fs_len_m1 = 8'd0; cfg_fs_chan = 1'b0;
    cfg_fs_early = 1'b0; cfg_fs_pol = 1'b1; cfg_slots_m1 = 4'd1;
    cfg_slot_size = 2'd0; cfg_data_size = 3'd7; cfg_first_bit = 5'd0;
    cfg_slot_mask = 16'd0; cfg_mono = 1'b0; cfg_sck_rise = 1'b0;
    load_words(3, 32'hF00D_1234);
    do_reset();
    run_frames(2, "R11 R6 zero fill", "R2 sync");
  endtask

  // R12: slot narrower than sample, then an unusable sample code
  task automatic t_illegal();
    for (int k = 0; k < 2; k++) begin
      cfg_slot_size = (k == 0) ? 2'd1 : 2'd0;
      cfg_data_size = (k == 0) ? 3'd7 : 3'd0;
      cfg_fs_pol = 1'b1;
      do_reset();
      s_valid = 1'b1;
      s_data = 32'hFFFF_FFFF;
      for (int c = 0; c < 20; c++) begin
        #1;
        chk(s_ready == 1'b0, "R12 no ready", 32'(s_ready), 0);
        @(negedge clk);
        chk(sd_o == 1'b0, "R12 sd idle", 32'(sd_o), 0);
        chk(fs_o == 1'b0, "R12 fs inactive", 32'(fs_o), 0);
        chk(underrun_o == 1'b0, "R12 no underrun", 32'(underrun_o), 0);
      end
      s_valid = 1'b0;
    end
  endtask

  initial begin
    #(PERIOD * LIMIT);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s_like();
    t_right_just();
    t_short_slots();
    t_mono();
    t_underrun();
    t_illegal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule